// File: doc/BRIEF.md
# Pipeline Result Forwarding Unit

This block chooses where each operand consumer in a five-stage pipeline gets its value from. There are four consumers: the two ALU operand inputs of the instruction in EX, the store-data input of that same instruction, and the zero comparator that resolves conditional branches in ID. Each consumer can take the register-file value or a result that has not yet been written back. The EX consumers can take the EX/MA result register (OUT0) or the MA/WB result register (OUT1). The branch comparator can take those two, and it can also take the ALU result that EX is computing in the same cycle. The block is purely combinational. It drives a select code and the chosen data value for every consumer, plus a zero flag for the branch operand.

Only a producer that writes a register other than r0 can supply a value. When more than one producer matches, the youngest one wins. A load's data exists only once it reaches OUT1. If a consumer depends on a load that sits in EX or in OUT0, the block forwards nothing for that consumer and raises a load-hazard flag. The interlock logic uses that flag to insert the single stall a load needs. Stalling itself and the register file sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: Each consumer's value output equals the source named by its 2-bit select: 0 = register-file value, 1 = OUT0 data, 2 = OUT1 data, 3 = live ALU result.
- R2: An ALU operand lane selects OUT0 or OUT1 when that producer's write-valid is set and its destination equals the lane's source register. With no match it selects the register file.
- R3: A producer whose destination is register 0, or whose write-valid is clear, is never forwarded. A lane whose source register is 0 always selects the register file.
- R4: When several producers match, the youngest wins: OUT0 over OUT1, and on the branch lane the live ALU result over OUT0.
- R5: The store-data lane follows the same matching and priority rules as the ALU operand lanes, independently of them.
- R6: The ALU operand lanes and the store-data lane never select code 3 (live ALU result).
- R7: The branch lane selects code 3 when the instruction in EX writes its source register and is not a load. The value comes from the ALU result in the same cycle, with no register in between.
- R8: If the youngest matching producer for an EX lane is a load in OUT0, that lane selects the register file and `ex_load_hz` is 1. Older producers are not used in that case. A load in OUT1 is forwarded normally.
- R9: If the youngest matching producer for the branch lane is a load in EX or in OUT0, the branch lane selects the register file and `id_load_hz` is 1.
- R10: `br_zero` is 1 exactly when the branch lane's value output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the embedded checks |
| rst_n | input | 1 | Active-low reset, used only by the embedded checks |
| ex_a_src | input | 5 | Source register of ALU operand A in EX |
| ex_a_rf | input | 32 | Register-file value for operand A |
| ex_b_src | input | 5 | Source register of ALU operand B in EX |
| ex_b_rf | input | 32 | Register-file value for operand B |
| st_src | input | 5 | Source register of store data in EX |
| st_rf | input | 32 | Register-file value for store data |
| br_src | input | 5 | Source register of the branch test in ID |
| br_rf | input | 32 | Register-file value for the branch test |
| ex_dst | input | 5 | Destination of the instruction in EX |
| ex_wen | input | 1 | Instruction in EX writes a register |
| ex_load | input | 1 | Instruction in EX is a load |
| ex_alu_res | input | 32 | ALU result being computed in EX |
| out0_dst | input | 5 | Destination held in OUT0 |
| out0_wen | input | 1 | OUT0 result will be written |
| out0_load | input | 1 | OUT0 belongs to a load (data not ready) |
| out0_data | input | 32 | OUT0 result value |
| out1_dst | input | 5 | Destination held in OUT1 |
| out1_wen | input | 1 | OUT1 result will be written |
| out1_data | input | 32 | OUT1 result value (ALU or loaded data) |
| ex_a_sel | output | 2 | Source select for operand A |
| ex_a_val | output | 32 | Forwarded operand A |
| ex_b_sel | output | 2 | Source select for operand B |
| ex_b_val | output | 32 | Forwarded operand B |
| st_sel | output | 2 | Source select for store data |
| st_val | output | 32 | Forwarded store data |
| br_sel | output | 2 | Source select for the branch test |
| br_val | output | 32 | Forwarded branch test operand |
| br_zero | output | 1 | Branch test operand is zero |
| ex_load_hz | output | 1 | An EX lane waits on a load in OUT0 |
| id_load_hz | output | 1 | The branch lane waits on a load in EX or OUT0 |

## Verification
The block holds no state, so a fault shows up at the ports in the same cycle as the stimulus that exposes it. A wrong priority or a wrong match shows as a select code that differs from the youngest valid producer. A wrong mux leg shows as a value that disagrees with the source its select names. A missed load block shows as a forwarded address together with a clear hazard flag. The stimulus draws register numbers from a small range, so producers often collide, both with each other and with r0. That makes these faults visible within a handful of cycles.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Select codes seen at the ports; order is fixed by the port contract.
    typedef enum logic [1:0] {
        SRC_RF   = 2'd0,
        SRC_OUT0 = 2'd1,
        SRC_OUT1 = 2'd2,
        SRC_ALU  = 2'd3
    } fwd_sel_e;

    // Producer slots scanned youngest first.
    localparam int NUM_PROD  = 3;
    localparam int SLOT_LIVE = 0;
    localparam int SLOT_OUT0 = 1;
    localparam int SLOT_OUT1 = 2;

    function automatic fwd_sel_e slot_to_sel(input int slot);
        case (slot)
            SLOT_LIVE: return SRC_ALU;
            SLOT_OUT0: return SRC_OUT0;
            SLOT_OUT1: return SRC_OUT1;
            default:   return SRC_RF;
        endcase
    endfunction

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wen,
    input  logic              rdy,
    output logic              hit,
    output logic              blk
);
    logic match;

    always_comb begin
        match = wen && (dst != '0) && (dst == src);
        hit   = match && rdy;
        blk   = match && !rdy;
    end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
    import fwd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int REG_AW   = 5,
    parameter bit USE_LIVE = 1'b0,
    parameter bit ENABLE   = 1'b1
) (
    input  logic [REG_AW-1:0] src,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [REG_AW-1:0] live_dst,
    input  logic              live_wen,
    input  logic              live_load,
    input  logic [DATA_W-1:0] live_val,
    input  logic [REG_AW-1:0] o0_dst,
    input  logic              o0_wen,
    input  logic              o0_load,
    input  logic [DATA_W-1:0] o0_val,
    input  logic [REG_AW-1:0] o1_dst,
    input  logic              o1_wen,
    input  logic [DATA_W-1:0] o1_val,
    output fwd_sel_e          sel,
    output logic [DATA_W-1:0] val,
    output logic              hz
);
    logic [REG_AW-1:0] slot_dst [NUM_PROD];
    logic [NUM_PROD-1:0] slot_wen;
    logic [NUM_PROD-1:0] slot_rdy;
    logic [NUM_PROD-1:0] slot_hit;
    logic [NUM_PROD-1:0] slot_blk;

    // The live slot exists only on lanes that sit ahead of EX.
    assign slot_dst[SLOT_LIVE] = live_dst;
    assign slot_wen[SLOT_LIVE] = USE_LIVE && live_wen;
    assign slot_rdy[SLOT_LIVE] = !live_load;
    assign slot_dst[SLOT_OUT0] = o0_dst;
    assign slot_wen[SLOT_OUT0] = o0_wen;
    assign slot_rdy[SLOT_OUT0] = !o0_load;
    assign slot_dst[SLOT_OUT1] = o1_dst;
    assign slot_wen[SLOT_OUT1] = o1_wen;
    assign slot_rdy[SLOT_OUT1] = 1'b1;

    for (genvar k = 0; k < NUM_PROD; k++) begin : g_slot
        fwd_hit #(.REG_AW(REG_AW)) i_hit (
            .src (src),
            .dst (slot_dst[k]),
            .wen (slot_wen[k]),
            .rdy (slot_rdy[k]),
            .hit (slot_hit[k]),
            .blk (slot_blk[k])
        );
    end

    if (ENABLE) begin : g_fwd
        // Youngest slot decides; a blocked load shadows every older slot.
        always_comb begin
            logic done;
            sel  = SRC_RF;
            hz   = 1'b0;
            done = 1'b0;
            for (int k = 0; k < NUM_PROD; k++) begin
                if (!done) begin
                    if (slot_hit[k]) begin
                        sel  = slot_to_sel(k);
                        done = 1'b1;
                    end else if (slot_blk[k]) begin
                        hz   = 1'b1;
                        done = 1'b1;
                    end
                end
            end
        end
    end else begin : g_nofwd
        assign sel = SRC_RF;
        assign hz  = 1'b0;
    end

    always_comb begin
        case (sel)
            SRC_OUT0: val = o0_val;
            SRC_OUT1: val = o1_val;
            SRC_ALU:  val = live_val;
            default:  val = rf_val;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 5,
    parameter bit EN_ALU_FW = 1'b1,
    parameter bit EN_ST_FW  = 1'b1,
    parameter bit EN_BR_FW  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] ex_a_src,
    input  logic [DATA_W-1:0] ex_a_rf,
    input  logic [REG_AW-1:0] ex_b_src,
    input  logic [DATA_W-1:0] ex_b_rf,
    input  logic [REG_AW-1:0] st_src,
    input  logic [DATA_W-1:0] st_rf,
    input  logic [REG_AW-1:0] br_src,
    input  logic [DATA_W-1:0] br_rf,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [DATA_W-1:0] ex_alu_res,
    input  logic [REG_AW-1:0] out0_dst,
    input  logic              out0_wen,
    input  logic              out0_load,
    input  logic [DATA_W-1:0] out0_data,
    input  logic [REG_AW-1:0] out1_dst,
    input  logic              out1_wen,
    input  logic [DATA_W-1:0] out1_data,
    output logic [1:0]        ex_a_sel,
    output logic [DATA_W-1:0] ex_a_val,
    output logic [1:0]        ex_b_sel,
    output logic [DATA_W-1:0] ex_b_val,
    output logic [1:0]        st_sel,
    output logic [DATA_W-1:0] st_val,
    output logic [1:0]        br_sel,
    output logic [DATA_W-1:0] br_val,
    output logic              br_zero,
    output logic              ex_load_hz,
    output logic              id_load_hz
);
    localparam int NUM_EX = 3;   // operand A, operand B, store data

    logic [REG_AW-1:0] ex_src [NUM_EX];
    logic [DATA_W-1:0] ex_rf  [NUM_EX];
    fwd_sel_e          ex_sel [NUM_EX];
    logic [DATA_W-1:0] ex_val [NUM_EX];
    logic [NUM_EX-1:0] ex_hz;
    fwd_sel_e          br_sel_e;
    logic              br_hz;

    assign ex_src[0] = ex_a_src;  assign ex_rf[0] = ex_a_rf;
    assign ex_src[1] = ex_b_src;  assign ex_rf[1] = ex_b_rf;
    assign ex_src[2] = st_src;    assign ex_rf[2] = st_rf;

    for (genvar i = 0; i < NUM_EX; i++) begin : g_ex
        localparam bit LANE_EN = (i == NUM_EX - 1) ? EN_ST_FW : EN_ALU_FW;
        fwd_lane #(
            .DATA_W(DATA_W), .REG_AW(REG_AW), .USE_LIVE(1'b0), .ENABLE(LANE_EN)
        ) i_lane (
            .src      (ex_src[i]),
            .rf_val   (ex_rf[i]),
            .live_dst (ex_dst),
            .live_wen (ex_wen),
            .live_load(ex_load),
            .live_val (ex_alu_res),
            .o0_dst   (out0_dst),
            .o0_wen   (out0_wen),
            .o0_load  (out0_load),
            .o0_val   (out0_data),
            .o1_dst   (out1_dst),
            .o1_wen   (out1_wen),
            .o1_val   (out1_data),
            .sel      (ex_sel[i]),
            .val      (ex_val[i]),
            .hz       (ex_hz[i])
        );
    end

    fwd_lane #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .USE_LIVE(1'b1), .ENABLE(EN_BR_FW)
    ) i_br_lane (
        .src      (br_src),
        .rf_val   (br_rf),
        .live_dst (ex_dst),
        .live_wen (ex_wen),
        .live_load(ex_load),
        .live_val (ex_alu_res),
        .o0_dst   (out0_dst),
        .o0_wen   (out0_wen),
        .o0_load  (out0_load),
        .o0_val   (out0_data),
        .o1_dst   (out1_dst),
        .o1_wen   (out1_wen),
        .o1_val   (out1_data),
        .sel      (br_sel_e),
        .val      (br_val),
        .hz       (br_hz)
    );

    assign ex_a_sel   = ex_sel[0];
    assign ex_a_val   = ex_val[0];
    assign ex_b_sel   = ex_sel[1];
    assign ex_b_val   = ex_val[1];
    assign st_sel     = ex_sel[2];
    assign st_val     = ex_val[2];
    assign br_sel     = br_sel_e;
    assign br_zero    = (br_val == '0);
    assign ex_load_hz = |ex_hz;
    assign id_load_hz = br_hz;

    // R3
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_a_src == '0) |-> (ex_a_sel == SRC_RF));

    // R4
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_src != '0 && out0_wen && out1_wen && !out0_load &&
         out0_dst == st_src && out1_dst == st_src) |-> (st_sel == SRC_OUT0));

    // R6
    ex_no_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_a_sel != SRC_ALU) && (ex_b_sel != SRC_ALU) && (st_sel != SRC_ALU));

    // R7
    br_live_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_sel == SRC_ALU) |-> (br_val == ex_alu_res));

    // R8
    out0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out0_load && out0_wen && ex_b_src != '0 && out0_dst == ex_b_src)
        |-> (ex_load_hz && ex_b_sel == SRC_RF));

    // R9
    br_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load && ex_wen && br_src != '0 && ex_dst == br_src)
        |-> (id_load_hz && br_sel == SRC_RF));

    // R10
    br_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_zero |-> (br_val == '0));
endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
    localparam int DW = 32;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [AW-1:0] ex_a_src, ex_b_src, st_src, br_src, ex_dst, out0_dst, out1_dst;
    logic [DW-1:0] ex_a_rf, ex_b_rf, st_rf, br_rf, ex_alu_res, out0_data, out1_data;
    logic          ex_wen, ex_load, out0_wen, out0_load, out1_wen;
    logic [1:0]    ex_a_sel, ex_b_sel, st_sel, br_sel;
    logic [DW-1:0] ex_a_val, ex_b_val, st_val, br_val;
    logic          br_zero, ex_load_hz, id_load_hz;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    fwd_unit i_fwd_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_a_src(ex_a_src), .ex_a_rf(ex_a_rf), .ex_b_src(ex_b_src), .ex_b_rf(ex_b_rf),
        .st_src(st_src), .st_rf(st_rf), .br_src(br_src), .br_rf(br_rf),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load), .ex_alu_res(ex_alu_res),
        .out0_dst(out0_dst), .out0_wen(out0_wen), .out0_load(out0_load), .out0_data(out0_data),
        .out1_dst(out1_dst), .out1_wen(out1_wen), .out1_data(out1_data),
        .ex_a_sel(ex_a_sel), .ex_a_val(ex_a_val), .ex_b_sel(ex_b_sel), .ex_b_val(ex_b_val),
        .st_sel(st_sel), .st_val(st_val), .br_sel(br_sel), .br_val(br_val),
        .br_zero(br_zero), .ex_load_hz(ex_load_hz), .id_load_hz(id_load_hz)
    );

    // Reference: list producers youngest first, take the first whose
    // destination equals the source; an unfinished load ends the search.
    task automatic ref_pick(input logic [AW-1:0] src, input logic [DW-1:0] rf,
                            input bit see_live, output logic [1:0] s,
                            output logic [DW-1:0] v, output bit hz);
        logic [AW-1:0] d[$];
        bit            w[$];
        bit            ld[$];
        logic [DW-1:0] dat[$];
        logic [1:0]    code[$];
        s = 2'd0; v = rf; hz = 0;
        if (see_live) begin
            d.push_back(ex_dst); w.push_back(ex_wen); ld.push_back(ex_load);
            dat.push_back(ex_alu_res); code.push_back(2'd3);
        end
        d.push_back(out0_dst); w.push_back(out0_wen); ld.push_back(out0_load);
        dat.push_back(out0_data); code.push_back(2'd1);
        d.push_back(out1_dst); w.push_back(out1_wen); ld.push_back(1'b0);
        dat.push_back(out1_data); code.push_back(2'd2);
        if (src == 0) return;   // R3
        for (int k = 0; k < d.size(); k++) begin
            if (w[k] && d[k] == src) begin
                if (ld[k]) begin hz = 1; return; end
                s = code[k]; v = dat[k]; return;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string ctx);
        logic [1:0] s; logic [DW-1:0] v; bit h; bit exhz;
        exhz = 0;
        ref_pick(ex_a_src, ex_a_rf, 0, s, v, h); exhz |= h;
        chk({ctx, " R2 R1 operand A"}, {ex_a_sel, ex_a_val}, {s, v});
        ref_pick(ex_b_src, ex_b_rf, 0, s, v, h); exhz |= h;
        chk({ctx, " R2 R6 operand B"}, {ex_b_sel, ex_b_val}, {s, v});
        ref_pick(st_src, st_rf, 0, s, v, h); exhz |= h;
        chk({ctx, " R5 store data"}, {st_sel, st_val}, {s, v});
        chk({ctx, " R8 ex_load_hz"}, {{DW+1{1'b0}}, ex_load_hz}, {{DW+1{1'b0}}, exhz});
        ref_pick(br_src, br_rf, 1, s, v, h);
        chk({ctx, " R7 R4 branch lane"}, {br_sel, br_val}, {s, v});
        chk({ctx, " R9 id_load_hz"}, {{DW+1{1'b0}}, id_load_hz}, {{DW+1{1'b0}}, h});
        chk({ctx, " R10 br_zero"}, {{DW+1{1'b0}}, br_zero}, {{DW+1{1'b0}}, (v == 0)});
    endtask

    task automatic clear_in();
        ex_a_src = 0; ex_b_src = 0; st_src = 0; br_src = 0;
        ex_a_rf = 32'h1111_0001; ex_b_rf = 32'h2222_0002; st_rf = 32'h3333_0003; br_rf = 32'h4444_0004;
        ex_dst = 0; ex_wen = 0; ex_load = 0; ex_alu_res = 32'hAAAA_0000;
        out0_dst = 0; out0_wen = 0; out0_load = 0; out0_data = 32'hBBBB_0000;
        out1_dst = 0; out1_wen = 0; out1_data = 32'hCCCC_0000;
    endtask

    task automatic step(input string ctx);
        @(negedge clk);
        compare_all(ctx);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1;
        step("reset R1");
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R2: operand A from OUT1, B from OUT0
        ex_a_src = 5; out1_dst = 5; out1_wen = 1;
        ex_b_src = 6; out0_dst = 6; out0_wen = 1;
        step("R2 match");
        // R3: writer to r0, and a non-writing producer
        clear_in(); ex_a_src = 0; out0_dst = 0; out0_wen = 1;
        st_src = 7; out1_dst = 7; out1_wen = 0;
        step("R3 r0/no-write");
        // R4: OUT0 beats OUT1, live beats OUT0 on branch lane
        clear_in(); st_src = 9; br_src = 9; out0_dst = 9; out0_wen = 1;
        out1_dst = 9; out1_wen = 1; ex_dst = 9; ex_wen = 1;
        step("R4 priority");
        // R7: live ALU result zero on branch lane
        clear_in(); br_src = 3; ex_dst = 3; ex_wen = 1; ex_alu_res = 0;
        step("R7 live zero");
        // R8: load in OUT0 shadows OUT1; load data in OUT1 forwarded
        clear_in(); ex_b_src = 4; out0_dst = 4; out0_wen = 1; out0_load = 1;
        out1_dst = 4; out1_wen = 1; ex_a_src = 8;
        step("R8 load OUT0");
        clear_in(); ex_a_src = 8; out1_dst = 8; out1_wen = 1;
        step("R8 load OUT1");
        // R9: load in EX blocks branch lane
        clear_in(); br_src = 2; ex_dst = 2; ex_wen = 1; ex_load = 1; out0_dst = 2; out0_wen = 1;
        step("R9 load EX");

        for (int n = 0; n < 3000; n++) begin
            ex_a_src = AW'($urandom_range(0, 3)); ex_b_src = AW'($urandom_range(0, 3));
            st_src = AW'($urandom_range(0, 3));   br_src = AW'($urandom_range(0, 3));
            ex_dst = AW'($urandom_range(0, 3));   out0_dst = AW'($urandom_range(0, 3));
            out1_dst = AW'($urandom_range(0, 3));
            ex_wen = 1'($urandom); ex_load = ($urandom_range(0, 3) == 0);
            out0_wen = 1'($urandom); out0_load = ($urandom_range(0, 3) == 0);
            out1_wen = 1'($urandom);
            ex_a_rf = $urandom; ex_b_rf = $urandom; st_rf = $urandom;
            br_rf = ($urandom_range(0, 4) == 0) ? 0 : $urandom;
            ex_alu_res = ($urandom_range(0, 4) == 0) ? 0 : $urandom;
            out0_data = $urandom; out1_data = ($urandom_range(0, 4) == 0) ? 0 : $urandom;
            step("random");
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule